// File: doc/BRIEF.md
# Landing Pad Control-Flow Checker

This block observes the instructions retiring from a RISC-V pipeline and enforces forward-edge control-flow integrity. It holds one state bit that marks a landing pad as expected. When the feature is enabled, an indirect jump that is neither a function return nor a software-guarded branch sets this bit. The next valid instruction must then be a landing pad (an AUIPC that writes x0), placed at a 4-byte aligned address, and its embedded label must agree with register x7. If any of these conditions fails, the block raises a one-cycle software-check exception strobe with a fixed cause and trap value.

The trap delivery logic reads the cause and trap value from the strobe. The bit is exported so that other logic can see it. The block does not decode other instructions, compute targets, or save the bit across privilege changes.

Top module: `lpad_cfi_check`

## Requirements
- R1: After an active-low reset, the expected bit is 0 and no exception strobe is raised.
- R2: With enable high, a valid JALR sets the expected bit on the next clock when its rs1 (bits [19:15]) is not 1, 5 or 7. JALR is decoded as opcode 1100111 with funct3 000.
- R3: A valid JALR whose rs1 is 1, 5 or 7 leaves the expected bit unchanged.
- R4: A landing pad is decoded as opcode 0010111 with rd = 0, and its label is bits [31:12]. When the expected bit is clear, a landing pad raises nothing and changes nothing.
- R5: When a landing pad is seen while the expected bit is set, the bit clears on the next clock, whether or not an exception is raised.
- R6: When a landing pad is checked and its PC bits [1:0] are nonzero, the block raises the exception.
- R7: When a landing pad is checked with a nonzero label that differs from x7[31:12], the block raises the exception. A matching label raises nothing.
- R8: A landing pad with label zero skips the label comparison.
- R9: When the expected bit is set and the next valid instruction is not a landing pad, the block raises the exception and clears the bit.
- R10: The exception is a one-cycle registered strobe that follows the offending instruction by one clock. It carries cause 18 and trap value 2.
- R11: While enable is low, the bit is never set and no exception is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Feature enable |
| ins_vld | input | 1 | Retiring instruction valid |
| ins_word | input | 32 | Instruction word |
| ins_pc | input | 32 | Instruction program counter |
| x7_val | input | 32 | Current value of x7 |
| exc_vld | output | 1 | Software-check exception strobe |
| exc_cause | output | 8 | Exception cause code (18) |
| exc_tval | output | 32 | Trap value (2) |
| lp_expect | output | 1 | Expected-landing-pad bit |

## Verification
The bench sends each of the jump register sources 1, 5 and 7 and compares them with other sources, which shows whether the return and guarded exemptions are decoded correctly. After the bit is armed, it sends landing pads that are aligned and misaligned, that have zero, matching and mismatching labels, and also a non-landing-pad instruction. Each of these separates one failure cause from the others. The bench also sends idle cycles while the bit is armed, stray landing pads and AUIPC with rd nonzero, and toggles enable. These cases show that invalid slots, unexpected pads and a disabled feature cause no side effects. A behavioural model predicts the bit and the strobe, and the bench compares them on every clock.

// File: rtl/lpad_cfi_check.sv
module lpad_cfi_check #(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 8,
  parameter int LBL_W     = 20,
  parameter logic [CAUSE_W-1:0] SWCHK_CAUSE = 8'd18,
  parameter logic [XLEN-1:0]    FCFI_TVAL   = 32'd2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               ins_vld,
  input  logic [31:0]        ins_word,
  input  logic [XLEN-1:0]    ins_pc,
  input  logic [XLEN-1:0]    x7_val,
  output logic               exc_vld,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [XLEN-1:0]    exc_tval,
  output logic               lp_expect
);
  localparam int LBL_LO = XLEN - LBL_W;

  logic [6:0] opc;
  logic [4:0] rd, rs1;
  logic [2:0] f3;
  logic [LBL_W-1:0] lbl;
  logic is_jalr, is_lpad, arms, bad_align, bad_lbl, fault;

  assign opc = ins_word[6:0];
  assign rd  = ins_word[11:7];
  assign f3  = ins_word[14:12];
  assign rs1 = ins_word[19:15];
  assign lbl = ins_word[31:12];

  assign is_jalr = opc == 7'b1100111 && f3 == 3'b000;
  assign is_lpad = opc == 7'b0010111 && rd == 5'd0;
  assign arms    = ins_vld && en && is_jalr &&
                   rs1 != 5'd1 && rs1 != 5'd5 && rs1 != 5'd7;

  assign bad_align = ins_pc[1:0] != 2'b00;
  assign bad_lbl   = lbl != '0 && lbl != x7_val[XLEN-1:LBL_LO];
  assign fault     = ins_vld && en && lp_expect &&
                     (!is_lpad || bad_align || bad_lbl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_expect <= 1'b0;
      exc_vld   <= 1'b0;
    end else begin
      exc_vld <= fault;
      if (arms)
        lp_expect <= 1'b1;
      else if (ins_vld && lp_expect)
        lp_expect <= 1'b0;
      else if (!en)
        lp_expect <= 1'b0;
    end
  end

  assign exc_cause = SWCHK_CAUSE;
  assign exc_tval  = FCFI_TVAL;

  p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !exc_vld && !lp_expect);
  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vld |=> !exc_vld || $past(ins_vld));
  p_exc_needs_expect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vld |-> $past(lp_expect) && $past(ins_vld));
  p_ret_no_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ins_vld && !lp_expect && is_jalr && (rs1 == 5'd1 || rs1 == 5'd5 || rs1 == 5'd7)
    |=> !lp_expect);
  p_lpad_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_vld && lp_expect && is_lpad |=> !lp_expect);
  p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arms |=> lp_expect);
  p_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vld |-> exc_cause == 8'd18 && exc_tval == 32'd2);
endmodule

// File: tb/lpad_cfi_check_tb.sv
module lpad_cfi_check_tb;
  logic clk = 0, rst_n = 0, en = 0, vld = 0;
  logic [31:0] word = 0, pc = 0, x7 = 0;
  logic exc_vld, lp_expect;
  logic [7:0] exc_cause;
  logic [31:0] exc_tval;
  int nchk = 0, nerr = 0, cyc = 0;
  bit m_exp = 0, m_exc = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  lpad_cfi_check u_dut (.clk(clk), .rst_n(rst_n), .en(en), .ins_vld(vld),
    .ins_word(word), .ins_pc(pc), .x7_val(x7), .exc_vld(exc_vld),
    .exc_cause(exc_cause), .exc_tval(exc_tval), .lp_expect(lp_expect));

  function automatic [31:0] jalr(input int r);
    return {12'h0, r[4:0], 3'b000, 5'd1, 7'b1100111};
  endfunction
  function automatic [31:0] auipc(input logic [19:0] l, input int r);
    return {l, r[4:0], 7'b0010111};
  endfunction

  task automatic chk(input string t, input logic [31:0] a, input logic [31:0] e);
    nchk++;
    if (a !== e) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", t, a, e);
    end
  endtask

  always @(posedge clk) begin
    bit nxt_e, nxt_x, isj, isl, bad;
    logic [4:0] r;
    cyc++;
    isj = word[6:0] == 7'b1100111 && word[14:12] == 0;
    isl = word[6:0] == 7'b0010111 && word[11:7] == 0;
    r = word[19:15];
    bad = !isl || pc[1:0] != 0 || (word[31:12] != 0 && word[31:12] != x7[31:12]);
    nxt_e = m_exp; nxt_x = 0;
    if (!rst_n) nxt_e = 0;
    else begin
      if (!en) nxt_e = 0;
      if (vld && en && m_exp) nxt_x = bad;
      if (vld && m_exp) nxt_e = 0;
      if (vld && en && isj && r != 1 && r != 5 && r != 7) nxt_e = 1;
    end
    m_exp <= nxt_e; m_exc <= nxt_x;
  end

  always @(negedge clk) if (rst_n) begin
    chk({tag, " expect bit"}, lp_expect, m_exp);
    chk({tag, " exc strobe"}, exc_vld, m_exc);
    if (exc_vld) begin
      chk("R10 cause", exc_cause, 18);
      chk("R10 tval", exc_tval, 2);
    end
  end

  task automatic step(input string t, input bit v, input logic [31:0] w,
                      input logic [31:0] p = 0, input logic [31:0] x = 0);
    @(posedge clk); #1;
    tag = t; vld = v; word = w; pc = p; x7 = x;
  endtask

  initial begin
    #1000000;
    nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset expect", lp_expect, 0);
    chk("R1 reset exc", exc_vld, 0);
    en = 1;
    step("R2", 1, jalr(10));
    step("R5", 1, auipc(0, 0), 32'h100);
    step("R3", 1, jalr(1));
    step("R3", 1, jalr(5));
    step("R3", 1, jalr(7));
    step("R4", 1, auipc(20'h12345, 0), 32'h102);
    step("R2", 1, jalr(6));
    step("R9", 0, jalr(6));
    step("R7", 1, auipc(20'hABCDE, 0), 32'h200, 32'hABCDE000);
    step("R2", 1, jalr(3));
    step("R7", 1, auipc(20'hABCDE, 0), 32'h200, 32'hABCDF000);
    step("R2", 1, jalr(0));
    step("R6", 1, auipc(0, 0), 32'h202);
    step("R2", 1, jalr(31));
    step("R8", 1, auipc(0, 0), 32'h300, 32'hFFFFF000);
    step("R2", 1, jalr(2));
    step("R9", 1, 32'h00000013);
    step("R2", 1, jalr(4));
    step("R9", 1, auipc(20'h1, 3), 32'h400);
    step("R2", 1, jalr(9));
    step("R2", 1, jalr(12));
    step("R5", 1, auipc(20'h5, 0), 32'h500, 32'h5000);
    step("R11", 1, jalr(10));
    en = 0;
    step("R11", 1, jalr(11));
    step("R11", 1, auipc(20'h9, 0), 32'h3);
    step("R11", 1, 32'h13);
    en = 1;
    step("R2", 1, jalr(8));
    step("R6", 1, auipc(20'h7, 0), 32'h601, 32'h7000);
    for (int i = 0; i < 40; i++)
      step("R2", 1, (i % 3 == 0) ? jalr(i % 32) : auipc(i[19:0] & 20'h3, 0), {i[29:0], 2'b00}, 32'h1000);
    step("R4", 0, 0);
    step("R4", 0, 0);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule